// File: doc/BRIEF.md
# UART Interrupt and Control Register Bank

This block is the software-visible register file of a UART. A simple word-addressed bus reads and writes 32-bit registers for interrupt state, interrupt enable, interrupt test, control, status, received data, transmit data, FIFO control and FIFO status. Four level interrupt lines come out of it, one each for transmit watermark, receive watermark, transmit empty and receive overflow. Each line is the AND of a sticky state bit and its enable bit.

Event pulses come in from the transmit FIFO and the receive path. The receive path hands over one byte at a time with a count of the bytes received so far. The bank keeps the latest byte and runs the empty/idle handshake: a byte arriving clears the flags, and software reading the byte sets them again. Control and FIFO-control contents are exported to the serial logic. A write to the transmit data word becomes a one-cycle push toward the transmit FIFO.

Top module: `uart_csr_bank`

## Requirements
- R1: After reset, interrupt state, interrupt enable, control and FIFO control read 0. Status reads 0x0000003C. All four interrupt lines are low.
- R2: Interrupt bit order is 0 transmit watermark, 1 receive watermark, 2 transmit empty, 3 receive overflow. An event pulse sets its state bit on the next edge. Each interrupt line is high exactly while its state bit and its enable bit (offset 1) are both 1.
- R3: A write to offset 0 clears every state bit written as 1 and keeps the bits written as 0.
- R4: A write to offset 2 ORs the written low four bits into the state. A read of offset 2 returns 0.
- R5: The word index is byte address bits [ADDR_W-1:2]. Offsets are 0 state, 1 enable, 2 test, 3 control, 4 status, 5 read data, 6 write data, 7 FIFO control, 8 FIFO status. Unmapped offsets read 0. An access whose byte enables are not all 1, or whose address bits [1:0] are not 0, has no effect and reads 0.
- R6: With control bit 1 (receive enable) set, an arriving byte is stored in offset 5 bits [7:0]. Status bit 4 (receive idle) and bit 5 (receive empty) clear, and status bit 1 (receive full) sets. With receive disabled, an arriving byte is ignored.
- R7: A read of offset 5 while receive is enabled sets status bits 4 and 5 and clears bit 1 on the next edge. With receive disabled the read leaves the status unchanged. A byte arriving in the same cycle as the read takes precedence.
- R8: An accepted byte sets the receive-watermark state bit when the supplied byte count is greater than the FIFO-control field at bits [4:2].
- R9: Writes to offsets 4, 5 and 8 are ignored. A read of offset 6 returns 0. A write to offset 6 raises tx_push for that cycle with tx_push_data equal to write data bits [7:0].
- R10: When an event sets a state bit in the same cycle that software clears it, the bit ends up set.
- R11: Status bit 0 (transmit full) is 1 when tx_level equals TX_DEPTH. Bits 2 (transmit empty) and 3 (transmit idle) are 1 when tx_level is 0. These bits are registered one edge after tx_level. Offset 8 reads tx_level in its low bits.
- R12: Control (offset 3) and FIFO control (offset 7) store the full written word and appear on cfg_ctrl and cfg_fifo_ctrl. Writing FIFO control with bit 1 set raises tx_fifo_clr for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables, must be all 1 |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle as the request |
| ev_tx_wm | input | 1 | Transmit watermark event pulse |
| ev_tx_empty | input | 1 | Transmit empty event pulse |
| ev_rx_ovf | input | 1 | Receive overflow event pulse |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_count | input | RXCNT_W | Bytes received so far, including this one |
| tx_level | input | TXLVL_W | Transmit FIFO fill level |
| irq_tx_wm | output | 1 | Transmit watermark interrupt |
| irq_rx_wm | output | 1 | Receive watermark interrupt |
| irq_tx_empty | output | 1 | Transmit empty interrupt |
| irq_rx_ovf | output | 1 | Receive overflow interrupt |
| cfg_ctrl | output | 32 | Control register contents |
| cfg_fifo_ctrl | output | 32 | FIFO control register contents |
| tx_push | output | 1 | Transmit data write strobe |
| tx_push_data | output | 8 | Byte to push |
| tx_fifo_clr | output | 1 | Transmit FIFO clear strobe |

## Verification
The bench forces an event and a software clear of the same state bit into one cycle. If clear took priority, the interrupt would be lost without a trace. It masks a source and then raises it, to show the state bit stays latched and the line rises later when the enable is written. It sends partial and misaligned writes to control, which a decoder that ignores the byte enables or address bits [1:0] would accept. It reads the data word with receive disabled, which a careless handshake would treat as consuming the byte. It checks the watermark at the count equal to the level and at one above it, which an off-by-one comparison gets wrong.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  localparam int NREG      = 9;
  localparam int IRQ_N     = 4;

  // word offsets
  localparam int OFS_ISTATE = 0;
  localparam int OFS_IEN    = 1;
  localparam int OFS_ITEST  = 2;
  localparam int OFS_CTRL   = 3;
  localparam int OFS_STATUS = 4;
  localparam int OFS_RDATA  = 5;
  localparam int OFS_WDATA  = 6;
  localparam int OFS_FCTRL  = 7;
  localparam int OFS_FSTAT  = 8;

  // interrupt bit positions
  localparam int IB_TXWM  = 0;
  localparam int IB_RXWM  = 1;
  localparam int IB_TXEMP = 2;
  localparam int IB_RXOVF = 3;

  // status bit positions
  localparam int SB_TXFULL = 0;
  localparam int SB_RXFULL = 1;
  localparam int SB_TXEMP  = 2;
  localparam int SB_TXIDLE = 3;
  localparam int SB_RXIDLE = 4;
  localparam int SB_RXEMP  = 5;

  // control / fifo control fields
  localparam int CB_RXEN     = 1;
  localparam int FB_TXCLR    = 1;
  localparam int F_RXLVL_LSB = 2;

  // sticky merge: clear first, then set, so a set always wins
  function automatic logic [IRQ_N-1:0] irq_merge(input logic [IRQ_N-1:0] cur,
                                                  input logic [IRQ_N-1:0] clr,
                                                  input logic [IRQ_N-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic wm_hit(input logic [31:0] cnt, input logic [31:0] lvl);
    return cnt > lvl;
  endfunction

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  output logic              acc_ok,
  output logic [WORD_W-1:0] word_idx,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel
);

  assign word_idx = req_addr[ADDR_W-1:2];
  assign acc_ok   = req_valid && (&req_be) && (req_addr[1:0] == 2'b00);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    logic hit;
    assign hit       = acc_ok && (word_idx == WORD_W'(g));
    assign wr_sel[g] = hit && req_write;
    assign rd_sel[g] = hit && !req_write;
  end

endmodule

// File: rtl/uart_csr_irq.sv
module uart_csr_irq
  import uart_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_state,
  input  logic             wr_enable,
  input  logic             wr_test,
  input  logic [IRQ_N-1:0] wdata,
  input  logic [IRQ_N-1:0] events,
  output logic [IRQ_N-1:0] state_q,
  output logic [IRQ_N-1:0] enable_q,
  output logic [IRQ_N-1:0] irq_o
);

  logic [IRQ_N-1:0] clr_vec;
  logic [IRQ_N-1:0] set_vec;

  assign clr_vec = wr_state ? wdata : '0;
  assign set_vec = events | (wr_test ? wdata : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= '0;
      enable_q <= '0;
    end else begin
      state_q <= irq_merge(state_q, clr_vec, set_vec);
      if (wr_enable) enable_q <= wdata;
    end
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
    assign irq_o[i] = state_q[i] & enable_q[i];
  end

endmodule

// File: rtl/uart_csr_rx.sv
module uart_csr_rx
  import uart_csr_pkg::*;
#(
  parameter int RXCNT_W = 4,
  parameter int RXLVL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic [RXCNT_W-1:0] rx_count,
  input  logic [RXLVL_W-1:0] rx_level,
  input  logic               rd_data,
  output logic [7:0]         data_q,
  output logic               idle_q,
  output logic               empty_q,
  output logic               accept,
  output logic               wm_event
);

  assign accept   = rx_valid && rx_en;
  assign wm_event = accept && wm_hit(32'(rx_count), 32'(rx_level));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      idle_q  <= 1'b1;
      empty_q <= 1'b1;
    end else if (accept) begin
      data_q  <= rx_data;
      idle_q  <= 1'b0;
      empty_q <= 1'b0;
    end else if (rd_data && rx_en) begin
      idle_q  <= 1'b1;
      empty_q <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_csr_bank.sv
module uart_csr_bank
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int TX_DEPTH = 16,
  parameter int RXCNT_W  = 4,
  parameter int RXLVL_W  = 3,
  localparam int TXLVL_W = $clog2(TX_DEPTH + 1),
  localparam int WORD_W  = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [3:0]         req_be,
  input  logic [31:0]        req_wdata,
  output logic [31:0]        rsp_rdata,
  input  logic               ev_tx_wm,
  input  logic               ev_tx_empty,
  input  logic               ev_rx_ovf,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic [RXCNT_W-1:0] rx_count,
  input  logic [TXLVL_W-1:0] tx_level,
  output logic               irq_tx_wm,
  output logic               irq_rx_wm,
  output logic               irq_tx_empty,
  output logic               irq_rx_ovf,
  output logic [31:0]        cfg_ctrl,
  output logic [31:0]        cfg_fifo_ctrl,
  output logic               tx_push,
  output logic [7:0]         tx_push_data,
  output logic               tx_fifo_clr
);

  logic              acc_ok;
  logic [WORD_W-1:0] word_idx;
  logic [NREG-1:0]   wr_sel;
  logic [NREG-1:0]   rd_sel;

  uart_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .acc_ok(acc_ok), .word_idx(word_idx),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  logic [31:0] ctrl_q;
  logic [31:0] fctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      fctrl_q <= '0;
    end else begin
      if (wr_sel[OFS_CTRL])  ctrl_q  <= req_wdata;
      if (wr_sel[OFS_FCTRL]) fctrl_q <= req_wdata;
    end
  end

  // receive side
  logic       rx_en;
  logic [7:0] rdata_q;
  logic       rx_idle_q;
  logic       rx_empty_q;
  logic       rx_accept;
  logic       rx_wm_event;

  assign rx_en = ctrl_q[CB_RXEN];

  uart_csr_rx #(.RXCNT_W(RXCNT_W), .RXLVL_W(RXLVL_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_count(rx_count),
    .rx_level(fctrl_q[F_RXLVL_LSB +: RXLVL_W]),
    .rd_data(rd_sel[OFS_RDATA]), .data_q(rdata_q), .idle_q(rx_idle_q),
    .empty_q(rx_empty_q), .accept(rx_accept), .wm_event(rx_wm_event)
  );

  // interrupts
  logic [IRQ_N-1:0] irq_events;
  logic [IRQ_N-1:0] istate_q;
  logic [IRQ_N-1:0] ien_q;
  logic [IRQ_N-1:0] irq_vec;

  always_comb begin
    irq_events           = '0;
    irq_events[IB_TXWM]  = ev_tx_wm;
    irq_events[IB_RXWM]  = rx_wm_event;
    irq_events[IB_TXEMP] = ev_tx_empty;
    irq_events[IB_RXOVF] = ev_rx_ovf;
  end

  uart_csr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_state(wr_sel[OFS_ISTATE]),
    .wr_enable(wr_sel[OFS_IEN]), .wr_test(wr_sel[OFS_ITEST]),
    .wdata(req_wdata[IRQ_N-1:0]), .events(irq_events),
    .state_q(istate_q), .enable_q(ien_q), .irq_o(irq_vec)
  );

  assign irq_tx_wm    = irq_vec[IB_TXWM];
  assign irq_rx_wm    = irq_vec[IB_RXWM];
  assign irq_tx_empty = irq_vec[IB_TXEMP];
  assign irq_rx_ovf   = irq_vec[IB_RXOVF];

  // transmit status, registered from the FIFO level
  logic tx_full_q;
  logic tx_empty_q;
  logic tx_idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full_q  <= 1'b0;
      tx_empty_q <= 1'b1;
      tx_idle_q  <= 1'b1;
    end else begin
      tx_full_q  <= (tx_level == TXLVL_W'(TX_DEPTH));
      tx_empty_q <= (tx_level == '0);
      tx_idle_q  <= (tx_level == '0);
    end
  end

  logic [31:0] status_w;
  always_comb begin
    status_w            = '0;
    status_w[SB_TXFULL] = tx_full_q;
    status_w[SB_RXFULL] = !rx_empty_q;
    status_w[SB_TXEMP]  = tx_empty_q;
    status_w[SB_TXIDLE] = tx_idle_q;
    status_w[SB_RXIDLE] = rx_idle_q;
    status_w[SB_RXEMP]  = rx_empty_q;
  end

  // read mux
  always_comb begin
    rsp_rdata = '0;
    if (acc_ok && !req_write) begin
      case (word_idx)
        WORD_W'(OFS_ISTATE): rsp_rdata = 32'(istate_q);
        WORD_W'(OFS_IEN):    rsp_rdata = 32'(ien_q);
        WORD_W'(OFS_CTRL):   rsp_rdata = ctrl_q;
        WORD_W'(OFS_STATUS): rsp_rdata = status_w;
        WORD_W'(OFS_RDATA):  rsp_rdata = 32'(rdata_q);
        WORD_W'(OFS_FCTRL):  rsp_rdata = fctrl_q;
        WORD_W'(OFS_FSTAT):  rsp_rdata = 32'(tx_level);
        default:             rsp_rdata = '0;
      endcase
    end
  end

  assign cfg_ctrl      = ctrl_q;
  assign cfg_fifo_ctrl = fctrl_q;
  assign tx_push       = wr_sel[OFS_WDATA];
  assign tx_push_data  = req_wdata[7:0];
  assign tx_fifo_clr   = wr_sel[OFS_FCTRL] && req_wdata[FB_TXCLR];

endmodule

// File: rtl/uart_csr_bank_chk.sv
module uart_csr_bank_chk
  import uart_csr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [3:0]       req_be,
  input logic [31:0]      req_wdata,
  input logic [NREG-1:0]  wr_sel,
  input logic [NREG-1:0]  rd_sel,
  input logic [IRQ_N-1:0] irq_events,
  input logic [IRQ_N-1:0] istate_q,
  input logic [IRQ_N-1:0] ien_q,
  input logic             irq_tx_wm,
  input logic             irq_rx_wm,
  input logic [31:0]      ctrl_q,
  input logic [31:0]      status_w,
  input logic [7:0]       rdata_q,
  input logic             rx_accept,
  input logic             rx_en
);

  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel) && $onehot0(rd_sel));

  assert_partial_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_be != 4'hF) |=> $stable(ctrl_q) && $stable(ien_q));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[OFS_ISTATE] && req_wdata[IB_TXWM] && !irq_events[IB_TXWM]) |=> !irq_tx_wm);

  assert_test_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[OFS_ITEST] && req_wdata[IB_RXWM] && ien_q[IB_RXWM]) |=> irq_rx_wm);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[OFS_ISTATE] && req_wdata[IB_TXEMP] && irq_events[IB_TXEMP]) |=> istate_q[IB_TXEMP]);

  assert_rx_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |=> !status_w[SB_RXEMP] && !status_w[SB_RXIDLE]);

  assert_rx_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel[OFS_RDATA] && rx_en && !rx_accept) |=> status_w[SB_RXEMP] && status_w[SB_RXIDLE]);

  assert_rdata_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[OFS_RDATA] && !rx_accept) |=> $stable(rdata_q));

endmodule

bind uart_csr_bank uart_csr_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_be(req_be), .req_wdata(req_wdata), .wr_sel(wr_sel), .rd_sel(rd_sel),
  .irq_events(irq_events), .istate_q(istate_q), .ien_q(ien_q),
  .irq_tx_wm(irq_tx_wm), .irq_rx_wm(irq_rx_wm), .ctrl_q(ctrl_q),
  .status_w(status_w), .rdata_q(rdata_q), .rx_accept(rx_accept), .rx_en(rx_en)
);

// File: tb/sim_uart_csr_bank.sv
module sim_uart_csr_bank;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int TX_DEPTH = 16;
  localparam int RXCNT_W = 4;
  localparam int TXLVL_W = $clog2(TX_DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic ev_tx_wm = 1'b0, ev_tx_empty = 1'b0, ev_rx_ovf = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [RXCNT_W-1:0] rx_count = '0;
  logic [TXLVL_W-1:0] tx_level = '0;
  logic irq_tx_wm, irq_rx_wm, irq_tx_empty, irq_rx_ovf;
  logic [31:0] cfg_ctrl, cfg_fifo_ctrl;
  logic tx_push, tx_fifo_clr;
  logic [7:0] tx_push_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_csr_bank #(.ADDR_W(ADDR_W), .TX_DEPTH(TX_DEPTH), .RXCNT_W(RXCNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .ev_tx_wm(ev_tx_wm), .ev_tx_empty(ev_tx_empty),
    .ev_rx_ovf(ev_rx_ovf), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_count(rx_count), .tx_level(tx_level), .irq_tx_wm(irq_tx_wm),
    .irq_rx_wm(irq_rx_wm), .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf),
    .cfg_ctrl(cfg_ctrl), .cfg_fifo_ctrl(cfg_fifo_ctrl), .tx_push(tx_push),
    .tx_push_data(tx_push_data), .tx_fifo_clr(tx_fifo_clr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] d, input logic [3:0] be = 4'hF,
                    input int byte_off = 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_be = be;
    req_addr = ADDR_W'(ofs * 4 + byte_off); req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF;
  endtask

  task automatic rd(input int ofs, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_be = be;
    req_addr = ADDR_W'(ofs * 4);
    #1 d = rsp_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0; req_be = 4'hF;
  endtask

  task automatic rd_chk(input string req, input int ofs, input logic [31:0] exp);
    logic [31:0] v;
    rd(ofs, v);
    check(req, v, exp);
  endtask

  task automatic rx_byte(input logic [7:0] b, input int cnt);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_count = RXCNT_W'(cnt);
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 irqs", {28'd0, irq_rx_ovf, irq_tx_empty, irq_rx_wm, irq_tx_wm}, 32'h0);
    rd_chk("R1 state", 0, 32'h0);
    rd_chk("R1 enable", 1, 32'h0);
    rd_chk("R1 ctrl", 3, 32'h0);
    rd_chk("R1 status", 4, 32'h3C);
    rd_chk("R1 fifo ctrl", 7, 32'h0);
  endtask

  task automatic t_gate;
    wr(1, 32'h7);
    @(negedge clk); ev_rx_ovf = 1'b1; ev_tx_wm = 1'b1;
    @(posedge clk); #1; ev_rx_ovf = 1'b0; ev_tx_wm = 1'b0;
    @(negedge clk);
    check("R2 tx wm line", irq_tx_wm, 1'b1);
    check("R2 masked ovf line", irq_rx_ovf, 1'b0);
    rd_chk("R2 state latched", 0, 32'h9);
    wr(1, 32'hF);
    @(negedge clk);
    check("R2 ovf after enable", irq_rx_ovf, 1'b1);
  endtask

  task automatic t_w1c;
    wr(0, 32'h1);
    @(negedge clk);
    check("R3 cleared line", irq_tx_wm, 1'b0);
    rd_chk("R3 other bit kept", 0, 32'h8);
    wr(0, 32'h8);
    rd_chk("R3 all clear", 0, 32'h0);
  endtask

  task automatic t_test;
    wr(2, 32'h6);
    rd_chk("R4 test ORed", 0, 32'h6);
    check("R4 lines", {30'd0, irq_tx_empty, irq_rx_wm}, 32'h3);
    rd_chk("R4 test reads 0", 2, 32'h0);
    wr(0, 32'hF);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_be = 4'hF;
    req_addr = ADDR_W'(0); req_wdata = 32'h4; ev_tx_empty = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; ev_tx_empty = 1'b0;
    rd_chk("R10 set beats clear", 0, 32'h4);
    wr(0, 32'hF);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(3, 32'h3, 4'h7);
    rd_chk("R5 partial write dropped", 3, 32'h0);
    wr(3, 32'h3, 4'hF, 1);
    rd_chk("R5 misaligned write dropped", 3, 32'h0);
    rd_chk("R5 unmapped reads 0", 9, 32'h0);
    rd(4, v, 4'h3);
    check("R5 partial read 0", v, 32'h0);
  endtask

  task automatic t_cfg;
    wr(3, 32'h0000_0003);
    check("R12 cfg_ctrl", cfg_ctrl, 32'h3);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(7 * 4); req_wdata = 32'h2;
    #1 check("R12 tx clear strobe", tx_fifo_clr, 1'b1);
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
    wr(7, 32'h0000_0008);
    check("R12 cfg_fifo_ctrl", cfg_fifo_ctrl, 32'h8);
  endtask

  task automatic t_rx;
    rx_byte(8'hA5, 1);
    rd_chk("R6 status after byte", 4, 32'h0E);
    rd_chk("R6 data stored", 5, 32'hA5);
    rd_chk("R7 status after read", 4, 32'h3C);
  endtask

  task automatic t_wm;
    rx_byte(8'h01, 2);
    rd_chk("R8 count equal level", 0, 32'h0);
    rx_byte(8'h02, 3);
    rd_chk("R8 count above level", 0, 32'h2);
    wr(0, 32'hF);
    rd_chk("R7 drain", 5, 32'h02);
  endtask

  task automatic t_rx_off;
    wr(3, 32'h1);
    rx_byte(8'h5A, 1);
    rd_chk("R6 disabled byte ignored", 5, 32'h02);
    rd_chk("R6 disabled status", 4, 32'h3C);
    wr(3, 32'h3);
    rx_byte(8'h11, 1);
    wr(3, 32'h1);
    rd_chk("R7 disabled read data", 5, 32'h11);
    rd_chk("R7 disabled read no effect", 4, 32'h0E);
  endtask

  task automatic t_ignored;
    wr(4, 32'hFFFF_FFFF);
    rd_chk("R9 status write ignored", 4, 32'h0E);
    wr(5, 32'h0);
    rd_chk("R9 rdata write ignored", 5, 32'h11);
    wr(8, 32'h1F);
    rd_chk("R9 fifo status write ignored", 8, 32'h0);
    rd_chk("R9 wdata reads 0", 6, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ADDR_W'(6 * 4); req_wdata = 32'h1C3;
    #1 check("R9 push strobe", {23'd0, tx_push, tx_push_data}, {23'd0, 1'b1, 8'hC3});
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic t_tx_status;
    @(negedge clk); tx_level = TXLVL_W'(TX_DEPTH);
    @(posedge clk); #1;
    rd_chk("R11 full status", 4, 32'h03);
    rd_chk("R11 fifo status level", 8, 32'(TX_DEPTH));
    @(negedge clk); tx_level = TXLVL_W'(5);
    @(posedge clk); #1;
    rd_chk("R11 partial level status", 4, 32'h02);
    @(negedge clk); tx_level = '0;
    @(posedge clk); #1;
    rd_chk("R11 empty status", 4, 32'h0E);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_gate;
    t_w1c;
    t_test;
    t_set_wins;
    t_decode;
    t_cfg;
    t_rx;
    t_wm;
    t_rx_off;
    t_ignored;
    t_tx_status;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule